// File: doc/BRIEF.md
# Tagged Load/Store Unit

This block carries out the two memory instructions of a small coprocessor against a shared, word-addressed memory of 2048 words of 32 bits (8 KB). It receives an instruction word, the program counter of that instruction, the four 16-bit general registers and a valid strobe. It forms an effective word address from one register plus a signed word offset taken from the instruction. It then drives a single memory port and, for loads, a register write-back port.

A store does not write raw data alone. The low half of the target word receives the 16-bit data register. The high half receives a tag made of the storing instruction's program counter and the index of the register that supplied the address. Software can later read any word and tell which instruction wrote it. A load reads the addressed word and writes its low half back to a destination register one clock later, because the memory answers with one cycle of latency.

A request is accepted in every cycle in which the strobe is high, so loads and stores may follow each other back to back. A small state machine remembers what was accepted in the previous cycle. It has three states. `S_IDLE` means nothing is outstanding. `S_STORE_ACK` means a write was issued last cycle. `S_LOAD_RESP` means a read was issued last cycle. Every state moves to `S_STORE_ACK` on an accepted store, to `S_LOAD_RESP` on an accepted load, and to `S_IDLE` otherwise. `S_STORE_ACK` raises `done`. `S_LOAD_RESP` raises `done` and the write-back strobe.

Top module: `tagged_lsu`

## Requirements
- R1: When `req_valid` is high and `instr[31:28]` is 6 with `instr[27:25]` equal to 3'b100, a write is issued in the same cycle: `mem_en` and `mem_we` are both 1.
- R2: An instruction with opcode 6 whose bits [27:25] differ from 3'b100 is ignored. No memory access, no `done` and no write-back follow it, and the memory word it names keeps its contents.
- R3: The word address is the low 11 bits of the register selected by `instr[3:2]` plus the signed 11-bit offset in `instr[20:10]`, taken modulo 2048.
- R4: A store writes the 32-bit word {pc[10:0], 3'b000, instr[3:2], R[instr[1:0]][15:0]}.
- R5: When `req_valid` is high and `instr[31:28]` is 13, a read is issued in the same cycle: `mem_en` is 1 and `mem_we` is 0.
- R6: One cycle after a read request, `wb_en` and `done` are 1, `wb_idx` equals the request's `instr[1:0]`, and `wb_data` holds bits [15:0] of the word read. The upper half of that word has no effect on `wb_data`.
- R7: One cycle after a write request, `done` is 1 and `wb_en` is 0.
- R8: Any other opcode, or any cycle with `req_valid` low, causes no memory access. No `done` and no write-back follow in the next cycle.
- R9: Requests in consecutive cycles are each accepted and answered in order, one cycle after each request.
- R10: After reset, with no request, `mem_en`, `done` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Instruction in `instr` is to be executed this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 11 | Word address of the instruction |
| regs_flat | input | 64 | Four 16-bit registers, register k in bits [16k+15:16k] |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Word address |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Read word, valid one cycle after a read request |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 2 | Destination register index |
| wb_data | output | 16 | Value to write back |
| done | output | 1 | A memory instruction finished in this cycle |

## Verification
The bench builds the block with its default parameters: an 11-bit address, 16-bit registers and 32-bit words. Those widths make a full 2048-word behavioural memory cheap. They also make the wrap corners reachable: a base register of 0x07FF or 0xFFFF, and offsets of +1023 and -1024. Because the tag field equals the address width, the program counter fills the top of the word exactly, so any misplaced tag bit shows up in the stored value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam logic [3:0] OPC_STORE     = 4'd6;
    localparam logic [3:0] OPC_LOAD      = 4'd13;
    localparam logic [2:0] STORE_SUBCODE = 3'b100;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STORE_ACK,
        S_LOAD_RESP
    } lsu_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_STORE,
        OP_LOAD
    } lsu_op_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 11,
    parameter int SEL_W   = 2
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output lsu_op_e            op,
    output logic [SEL_W-1:0]   addr_sel,
    output logic [SEL_W-1:0]   data_sel,
    output logic [OFF_W-1:0]   offset
);
    localparam int OFF_LSB = 10;

    logic [3:0] opcode;
    logic [2:0] subcode;

    assign opcode   = instr[INSTR_W-1 -: 4];
    assign subcode  = instr[INSTR_W-5 -: 3];
    assign addr_sel = instr[2*SEL_W-1 -: SEL_W];
    assign data_sel = instr[SEL_W-1:0];
    assign offset   = instr[OFF_LSB +: OFF_W];

    always_comb begin
        op = OP_NONE;
        if (valid) begin
            if (opcode == OPC_STORE && subcode == STORE_SUBCODE) begin
                op = OP_STORE;
            end else if (opcode == OPC_LOAD) begin
                op = OP_LOAD;
            end
        end
    end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
    parameter int ADDR_W = 11,
    parameter int REG_W  = 16,
    parameter int OFF_W  = 11
) (
    input  logic [REG_W-1:0]  base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] base_lo;

    generate
        if (OFF_W >= ADDR_W) begin : g_off_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end else begin : g_off_sext
            assign off_ext = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        end
        if (REG_W >= ADDR_W) begin : g_base_trunc
            assign base_lo = base[ADDR_W-1:0];
        end else begin : g_base_zext
            assign base_lo = {{(ADDR_W-REG_W){1'b0}}, base};
        end
    endgenerate

    assign addr = base_lo + off_ext;
endmodule

// File: rtl/lsu_pack.sv
module lsu_pack #(
    parameter int WORD_W = 32,
    parameter int PC_W   = 11,
    parameter int SEL_W  = 2,
    parameter int REG_W  = 16
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic [REG_W-1:0]  data,
    output logic [WORD_W-1:0] word
);
    localparam int HALF_W = WORD_W / 2;
    localparam int PAD_W  = HALF_W - PC_W - SEL_W;

    logic [HALF_W-1:0] tag;
    logic [HALF_W-1:0] low;

    generate
        if (PAD_W > 0) begin : g_pad
            assign tag = {pc, {PAD_W{1'b0}}, addr_sel};
        end else begin : g_nopad
            assign tag = {pc, addr_sel};
        end
        if (REG_W >= HALF_W) begin : g_low_trunc
            assign low = data[HALF_W-1:0];
        end else begin : g_low_zext
            assign low = {{(HALF_W-REG_W){1'b0}}, data};
        end
    endgenerate

    assign word = {tag, low};
endmodule

// File: rtl/tagged_lsu.sv
module tagged_lsu
    import lsu_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int REG_W   = 16,
    parameter int NREGS   = 4,
    parameter int WORD_W  = 32,
    parameter int INSTR_W = 32,
    parameter int OFF_W   = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [INSTR_W-1:0]     instr,
    input  logic [ADDR_W-1:0]      pc,
    input  logic [NREGS*REG_W-1:0] regs_flat,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [WORD_W-1:0]      mem_wdata,
    input  logic [WORD_W-1:0]      mem_rdata,
    output logic                   wb_en,
    output logic [1:0]             wb_idx,
    output logic [REG_W-1:0]       wb_data,
    output logic                   done
);
    localparam int SEL_W  = $clog2(NREGS);
    localparam int HALF_W = WORD_W / 2;

    lsu_op_e           op;
    logic [SEL_W-1:0]  addr_sel;
    logic [SEL_W-1:0]  data_sel;
    logic [OFF_W-1:0]  offset;
    logic [REG_W-1:0]  base_val;
    logic [REG_W-1:0]  data_val;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] packed_word;

    lsu_state_e        state_q, state_d;
    logic [SEL_W-1:0]  wb_idx_q;

    lsu_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_dec (
        .valid    (req_valid),
        .instr    (instr),
        .op       (op),
        .addr_sel (addr_sel),
        .data_sel (data_sel),
        .offset   (offset)
    );

    assign base_val = regs_flat[addr_sel*REG_W +: REG_W];
    assign data_val = regs_flat[data_sel*REG_W +: REG_W];

    lsu_agu #(.ADDR_W(ADDR_W), .REG_W(REG_W), .OFF_W(OFF_W)) u_agu (
        .base   (base_val),
        .offset (offset),
        .addr   (eff_addr)
    );

    lsu_pack #(.WORD_W(WORD_W), .PC_W(ADDR_W), .SEL_W(SEL_W), .REG_W(REG_W)) u_pack (
        .pc       (pc),
        .addr_sel (addr_sel),
        .data     (data_val),
        .word     (packed_word)
    );

    always_comb begin
        unique case (op)
            OP_STORE: state_d = S_STORE_ACK;
            OP_LOAD:  state_d = S_LOAD_RESP;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            wb_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (op == OP_LOAD) begin
                wb_idx_q <= data_sel;
            end
        end
    end

    always_comb begin
        mem_en    = (op != OP_NONE);
        mem_we    = (op == OP_STORE);
        mem_addr  = eff_addr;
        mem_wdata = (op == OP_STORE) ? packed_word : '0;
        wb_en     = 1'b0;
        wb_idx    = '0;
        wb_data   = '0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                done = 1'b0;
            end
            S_STORE_ACK: begin
                done = 1'b1;
            end
            S_LOAD_RESP: begin
                done    = 1'b1;
                wb_en   = 1'b1;
                wb_idx  = wb_idx_q;
                wb_data = mem_rdata[REG_W-1:0];
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

    logic unused_hi;
    assign unused_hi = ^{mem_rdata[WORD_W-1:HALF_W], instr[9:4], instr[24:21]};
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        wb_en,
    input logic        done
);
    a_r1_we_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    a_r7_store_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (done && !wb_en));

    a_r6_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (done && wb_en));

    a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> (!done && !wb_en));

    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[20:18] == 3'b000));
endmodule

bind tagged_lsu lsu_checker u_lsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .wb_en     (wb_en),
    .done      (done)
);

// File: tb/tb_tagged_lsu.sv
module tb_tagged_lsu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [10:0] pc = '0;
    logic [63:0] regs_flat;
    logic        mem_en, mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        wb_en;
    logic [1:0]  wb_idx;
    logic [15:0] wb_data;
    logic        done;

    logic [15:0] r [4];
    logic [31:0] bmem [2048];

    int checks = 0;
    int errors = 0;
    bit p_done = 0, p_wb = 0;
    logic [1:0]  p_idx = '0;
    logic [15:0] p_data = '0;

    always #5 clk = ~clk;

    assign regs_flat = {r[3], r[2], r[1], r[0]};

    tagged_lsu dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr), .pc(pc),
        .regs_flat(regs_flat), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_data(wb_data), .done(done)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] st_ins(input int off, input int a, input int d);
        logic [10:0] o = off[10:0];
        return {4'd6, 3'b100, 4'b0000, o, 6'b0, a[1:0], d[1:0]};
    endfunction

    function automatic logic [31:0] ld_ins(input int off, input int a, input int d);
        logic [10:0] o = off[10:0];
        return {4'd13, 7'b0, o, 6'b0, a[1:0], d[1:0]};
    endfunction

    // Called at a negative edge: checks the response to the previous request,
    // drives a new one, checks the memory port, records the expected response.
    task automatic step(input bit v, input logic [31:0] ins, input logic [10:0] p, input string req);
        bit is_st, is_ld;
        int o, ea;
        logic [31:0] exp_word;
        chk(done == p_done, {req, " R6/R7/R8 done"}, {31'b0, done}, {31'b0, p_done});
        chk(wb_en == p_wb, {req, " R6/R7 wb_en"}, {31'b0, wb_en}, {31'b0, p_wb});
        if (p_wb) begin
            chk(wb_idx == p_idx, {req, " R6 wb_idx"}, {30'b0, wb_idx}, {30'b0, p_idx});
            chk(wb_data == p_data, {req, " R6 wb_data"}, {16'b0, wb_data}, {16'b0, p_data});
        end
        req_valid = v; instr = ins; pc = p;
        #1;
        is_st = v && ins[31:28] == 4'd6 && ins[27:25] == 3'b100;
        is_ld = v && ins[31:28] == 4'd13;
        o  = $signed(ins[20:10]);
        ea = (int'(r[ins[3:2]]) + o) & 2047;
        chk(mem_en == (is_st || is_ld), {req, " R1/R5/R2/R8 mem_en"}, {31'b0, mem_en}, {31'b0, is_st || is_ld});
        if (is_st || is_ld) begin
            chk(mem_we == is_st, {req, " R1/R5 mem_we"}, {31'b0, mem_we}, {31'b0, is_st});
            chk(int'(mem_addr) == ea, {req, " R3 address"}, {21'b0, mem_addr}, ea);
        end
        if (is_st) begin
            exp_word = {p, 3'b000, ins[3:2], r[ins[1:0]]};
            chk(mem_wdata == exp_word, {req, " R4 word"}, mem_wdata, exp_word);
        end
        p_done = is_st || is_ld;
        p_wb   = is_ld;
        p_idx  = ins[1:0];
        p_data = bmem[ea][15:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) bmem[i] = {16'hC000 | 16'(i), 16'(i * 7)};
        r[0] = 16'h0010; r[1] = 16'h07FF; r[2] = 16'h1234; r[3] = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_en == 0 && done == 0 && wb_en == 0, "R10 reset outputs", {29'b0, mem_en, done, wb_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, '0, '0, "R10 idle");

        // R1 R4: store r2 at r0+5 = 21
        step(1, st_ins(5, 0, 2), 11'h123, "R1 store");
        step(0, '0, '0, "R7 store ack");
        chk(bmem[21] == {11'h123, 3'b000, 2'd0, 16'h1234}, "R4 stored word", bmem[21], {11'h123, 3'b000, 2'd0, 16'h1234});

        // R3 wrap cases
        step(1, st_ins(-3, 0, 3), 11'h7FF, "R3 negative offset");
        step(1, st_ins(2, 1, 2), 11'h001, "R3 wrap up");
        step(1, st_ins(0, 3, 0), 11'h400, "R3 base 0xFFFF");
        step(1, st_ins(1023, 0, 1), 11'h055, "R3 max offset");
        step(1, st_ins(-1024, 2, 1), 11'h2AA, "R3 min offset");
        step(0, '0, '0, "R7 ack");

        // R5 R6: load back, upper half ignored
        step(1, ld_ins(5, 0, 3), 11'h0, "R5 load");
        chk(p_data == 16'h1234, "R6 load value", {16'b0, p_data}, 32'h1234);
        step(0, '0, '0, "R6 write-back");
        step(1, ld_ins(100, 0, 1), 11'h0, "R6 upper ignored");
        step(0, '0, '0, "R6 write-back 2");

        // R2: wrong subcode ignored, word at 16+40 unchanged
        step(1, {4'd6, 3'b101, 4'b0, 11'd40, 6'b0, 2'd0, 2'd2}, 11'h10, "R2 bad subcode");
        step(0, '0, '0, "R2 no ack");
        step(1, ld_ins(40, 0, 2), 11'h0, "R2 load untouched");
        chk(p_data == 16'(56 * 7), "R2 word unchanged", {16'b0, p_data}, 32'(16'(56 * 7)));
        step(0, '0, '0, "R2 wb");

        // R8: other opcode, and valid low with a store word
        step(1, {4'd7, 28'h0ABCDEF}, 11'h3, "R8 other opcode");
        step(0, st_ins(1, 0, 0), 11'h3, "R8 valid low");
        step(0, '0, '0, "R8 idle");

        // R9: back to back
        step(1, st_ins(7, 0, 2), 11'h321, "R9 store");
        step(1, ld_ins(7, 0, 0), 11'h322, "R9 load after store");
        step(1, ld_ins(-3, 0, 1), 11'h323, "R9 load");
        step(1, st_ins(8, 0, 3), 11'h324, "R9 store after load");
        step(1, ld_ins(8, 0, 2), 11'h325, "R9 load");
        step(0, '0, '0, "R9 drain");
        step(0, '0, '0, "R10 final idle");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule